// File: doc/BRIEF.md
# Dynamic VID Reference Stepper

This block turns a 5-bit voltage-identification (VID) code into the set-point code that a regulator reference DAC follows. The set-point is an integer count of 25 mV steps above 0.800 V, so the range 0 to 30 covers 0.800 V to 1.550 V. The block looks at the VID pins only on a once-per-switching-cycle strobe. It accepts a new code only after the code has held for more than one cycle. It then walks the reference one step per cycle until the reference reaches the accepted target.

While the reference is walking, a busy flag and a power-good mask are raised. Any VID movement in that time is not looked at. The all-ones code is reserved. When it is seen, the block enters a latched no-CPU state that the surrounding power stage uses to turn every switch off. Only reset leaves that state.

The control is a four-state machine:
- `ST_IDLE` watches for a differing code.
- `ST_QUAL` waits for the new code to hold.
- `ST_SLEW` steps the reference.
- `ST_NOCPU` is the sticky shutdown state.

Its transitions are:
- idle→qual on a differing code.
- qual→qual (restart) when the candidate changes.
- qual→idle when the code returns to the target.
- qual→slew on acceptance.
- slew→idle on the strobe that lands on the target.
- idle/qual→nocpu on code 11111.

Top module: `vid_ref_stepper`

## Requirements
- R1: After reset, `ref_code` is 0, `slew_busy` is 0, `pg_mask` is 0 and `nocpu_latched` is 0.
- R2: A VID value v in 0..30 selects the set-point count 30 − v (00000 is 1.550 V, 11110 is 0.800 V). `ref_code` never exceeds 30.
- R3: The VID input is sampled only on a clock edge where both `cyc_tick` and `en` are high. Without such a sample, no output changes.
- R4: A differing code is accepted only when it is seen on the first sample and then on STABLE_TICKS (default 2) further consecutive samples. With the default, `slew_busy` rises at the third sample.
- R5: If the candidate code changes during qualification, qualification restarts with the new code. If the code returns to the current target, qualification is dropped and no slew starts.
- R6: Once a target is accepted, `ref_code` moves by exactly one count per sample toward it. `slew_busy` stays high until the sample where `ref_code` equals the target, and falls on that same sample.
- R7: VID changes during a slew are ignored. Monitoring resumes on the first sample after the slew ends.
- R8: `pg_mask` is high exactly while a slew is in progress.
- R9: A sample of code 11111 while idle or qualifying sets `nocpu_latched`. It freezes `ref_code` and forces `slew_busy` and `pg_mask` low. The state is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Sampling enable |
| cyc_tick | input | 1 | One-clock strobe per switching cycle |
| vid_in | input | VID_W | VID code |
| ref_code | output | VID_W | Set-point count, 25 mV above 0.800 V |
| slew_busy | output | 1 | Reference transition in progress |
| pg_mask | output | 1 | Power-good masked |
| nocpu_latched | output | 1 | Reserved-code shutdown latched |

## Verification
The main function is driven with:
- a clean upward step and a downward step, which separate the step direction and the landing sample;
- a code that changes halfway through qualification, which shows the stability counter restarts rather than carrying over;
- a one-sample glitch back to the target, which must start no slew;
- a VID change during a slew, which must not alter the target;
- a full-range walk from 0 to 30 and back, which checks the end points and the exact number of steps.

Directed cases cover disabled and unstrobed clocks, and the sticky reserved code together with its release by reset.

// File: rtl/vidstep_pkg.sv
package vidstep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QUAL  = 2'd1,
        ST_SLEW  = 2'd2,
        ST_NOCPU = 2'd3
    } vs_state_e;
endpackage

// File: rtl/vid_decode.sv
module vid_decode #(
    parameter int VID_W = 5
) (
    input  logic [VID_W-1:0] vid,
    output logic [VID_W-1:0] code,
    output logic             reserved
);
    localparam logic [VID_W-1:0] ALL_ONES = '1;
    localparam logic [VID_W-1:0] TOP_CODE = ALL_ONES - 1'b1;

    always_comb begin
        reserved = (vid == ALL_ONES);
        code     = reserved ? '0 : (TOP_CODE - vid);
    end
endmodule

// File: rtl/stab_counter.sv
module stab_counter #(
    parameter int STABLE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int CW = $clog2(STABLE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clr)             cnt_q <= '0;
        else if (inc && !done)    cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LAST);

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/ref_slewer.sv
module ref_slewer #(
    parameter int VID_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [VID_W-1:0] target,
    output logic [VID_W-1:0] ref_code,
    output logic             last_step
);
    logic [VID_W-1:0] ref_q;
    logic             go_up;

    always_comb begin
        go_up     = (target > ref_q);
        last_step = go_up ? ((target - ref_q) == 1) : ((ref_q - target) == 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ref_q <= '0;
        else if (step_en) ref_q <= go_up ? ref_q + 1'b1 : ref_q - 1'b1;
    end

    assign ref_code = ref_q;

    // R6: a change is always a single count
    a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q != $past(ref_q)) |-> ((ref_q == $past(ref_q) + 1'b1) || (ref_q == $past(ref_q) - 1'b1)));
    // R3: no step without an enable from the controller
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step_en) |-> $stable(ref_q));
endmodule

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper
    import vidstep_pkg::*;
#(
    parameter int VID_W        = 5,
    parameter int STABLE_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cyc_tick,
    input  logic [VID_W-1:0] vid_in,
    output logic [VID_W-1:0] ref_code,
    output logic             slew_busy,
    output logic             pg_mask,
    output logic             nocpu_latched
);
    localparam logic [VID_W-1:0] MAX_CODE = {VID_W{1'b1}} - 1'b1;

    vs_state_e        state_q, state_d;
    logic [VID_W-1:0] cand_q, target_q;
    logic [VID_W-1:0] dec_code;
    logic             dec_rsv;
    logic             sample, cnt_done, last_step;
    logic             cnt_clr, cnt_inc, step_en, accept;

    vid_decode #(.VID_W(VID_W)) u_dec (
        .vid      (vid_in),
        .code     (dec_code),
        .reserved (dec_rsv)
    );

    stab_counter #(.STABLE_TICKS(STABLE_TICKS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .done  (cnt_done)
    );

    ref_slewer #(.VID_W(VID_W)) u_slew (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .target    (target_q),
        .ref_code  (ref_code),
        .last_step (last_step)
    );

    assign sample = cyc_tick && en;

    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        step_en = 1'b0;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (sample) begin
                cnt_clr = 1'b1;
                if (dec_rsv)                    state_d = ST_NOCPU;
                else if (dec_code != target_q)  state_d = ST_QUAL;
            end
            ST_QUAL: if (sample) begin
                if (dec_rsv)                    state_d = ST_NOCPU;
                else if (dec_code == target_q)  state_d = ST_IDLE;
                else if (dec_code != cand_q)    cnt_clr = 1'b1;
                else if (cnt_done) begin
                    accept  = 1'b1;
                    state_d = ST_SLEW;
                end
                else                            cnt_inc = 1'b1;
            end
            ST_SLEW: if (sample) begin
                step_en = 1'b1;
                if (last_step)                  state_d = ST_IDLE;
            end
            ST_NOCPU: state_d = ST_NOCPU;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q   <= '0;
            target_q <= '0;
        end else begin
            if (cnt_clr) cand_q   <= dec_code;
            if (accept)  target_q <= cand_q;
        end
    end

    always_comb begin
        slew_busy     = (state_q == ST_SLEW);
        pg_mask       = (state_q == ST_SLEW);
        nocpu_latched = (state_q == ST_NOCPU);
    end

    // R2: set-point stays in range
    a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
        ref_code <= MAX_CODE);
    // R9: shutdown latch is sticky and never busy
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(nocpu_latched) |-> nocpu_latched);
    a_r9_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        nocpu_latched |-> (!slew_busy && !pg_mask));
    // R7: target frozen throughout a slew
    a_r7_target_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SLEW && state_q == ST_SLEW) |-> $stable(target_q));
    // R6: reference still outside a slew
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!slew_busy && !$past(slew_busy)) |-> $stable(ref_code));
endmodule

// File: tb/vid_ref_stepper_tb.sv
module vid_ref_stepper_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       cyc_tick = 1'b0;
    logic [4:0] vid_in = 5'd30;
    logic [4:0] ref_code;
    logic       slew_busy, pg_mask, nocpu_latched;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // {vid, expected ref, expected busy}
    localparam logic [10:0] VEC [NVEC] = '{
        {5'd28, 5'd0, 1'b0}, {5'd28, 5'd0, 1'b0}, {5'd28, 5'd0, 1'b1},
        {5'd28, 5'd1, 1'b1}, {5'd28, 5'd2, 1'b0},
        {5'd30, 5'd2, 1'b0}, {5'd30, 5'd2, 1'b0}, {5'd30, 5'd2, 1'b1},
        {5'd5,  5'd1, 1'b1}, {5'd5,  5'd0, 1'b0}, {5'd30, 5'd0, 1'b0},
        {5'd29, 5'd0, 1'b0}, {5'd27, 5'd0, 1'b0}, {5'd27, 5'd0, 1'b0},
        {5'd27, 5'd0, 1'b1}, {5'd27, 5'd1, 1'b1}, {5'd27, 5'd2, 1'b1},
        {5'd27, 5'd3, 1'b0},
        {5'd26, 5'd3, 1'b0}, {5'd27, 5'd3, 1'b0}, {5'd27, 5'd3, 1'b0},
        {5'd26, 5'd3, 1'b0}, {5'd26, 5'd3, 1'b0}, {5'd26, 5'd3, 1'b1},
        {5'd26, 5'd4, 1'b0}
    };

    vid_ref_stepper u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .cyc_tick      (cyc_tick),
        .vid_in        (vid_in),
        .ref_code      (ref_code),
        .slew_busy     (slew_busy),
        .pg_mask       (pg_mask),
        .nocpu_latched (nocpu_latched)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [4:0] v);
        @(negedge clk);
        vid_in   = v;
        cyc_tick = 1'b1;
        @(negedge clk);
        cyc_tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ref", ref_code, 0);
        chk("R1 busy", slew_busy, 0);
        chk("R1 mask", pg_mask, 0);
        chk("R1 nocpu", nocpu_latched, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5 R6 R7 R8 vector walk
        for (int i = 0; i < NVEC; i++) begin
            strobe(VEC[i][10:6]);
            chk($sformatf("R6 vec%0d ref", i), ref_code, int'(VEC[i][5:1]));
            chk($sformatf("R4 vec%0d busy", i), slew_busy, int'(VEC[i][0]));
            chk($sformatf("R8 vec%0d mask", i), pg_mask, int'(VEC[i][0]));
        end

        // R3: clocks without a strobe, and strobes while disabled
        vid_in = 5'd0;
        repeat (6) @(negedge clk);
        chk("R3 no tick ref", ref_code, 4);
        chk("R3 no tick busy", slew_busy, 0);
        en = 1'b0;
        repeat (4) strobe(5'd0);
        chk("R3 disabled ref", ref_code, 4);
        chk("R3 disabled busy", slew_busy, 0);
        en = 1'b1;

        // R9 reserved code latches, ignores later codes
        strobe(5'd31);
        chk("R9 nocpu set", nocpu_latched, 1);
        chk("R9 busy low", slew_busy, 0);
        repeat (5) strobe(5'd28);
        chk("R9 nocpu held", nocpu_latched, 1);
        chk("R9 ref frozen", ref_code, 4);
        chk("R9 mask low", pg_mask, 0);
        do_reset();
        chk("R9 cleared by reset", nocpu_latched, 0);
        chk("R1 ref after reset", ref_code, 0);

        // R2 full range: vid 0 -> 30 counts, vid 30 -> 0 counts
        repeat (3) strobe(5'd0);
        chk("R4 full accept", slew_busy, 1);
        repeat (29) strobe(5'd0);
        chk("R6 full ref29", ref_code, 29);
        chk("R6 full busy29", slew_busy, 1);
        strobe(5'd0);
        chk("R2 top ref", ref_code, 30);
        chk("R6 top busy", slew_busy, 0);
        repeat (33) strobe(5'd30);
        chk("R2 bottom ref", ref_code, 0);
        chk("R6 bottom busy", slew_busy, 0);

        // R7 reserved code during a slew is ignored, then seen afterwards
        repeat (3) strobe(5'd29);
        strobe(5'd31);
        chk("R7 ignore rsv ref", ref_code, 1);
        chk("R7 ignore rsv nocpu", nocpu_latched, 0);
        strobe(5'd31);
        chk("R9 rsv after slew", nocpu_latched, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule